// File: doc/BRIEF.md
# Three-Phase Pattern Transfer Controller

This block decides when the buffered phase-pattern words are moved into the three-phase output shift register, and when the dead-time timer receives a start pulse. It merges three transfer sources into one transfer trigger: a carrier-timer underflow, a software trigger write, and a carrier-period write. The period write counts only when its enable input is high. The block also takes the falling edges of the one-shot pulses from the three phase timers. The timers themselves live outside the block.

The mode input selects the modulation scheme. In triangular modulation, every transfer trigger copies the buffers, and only one-shot falling edges start the dead-time timer. In sawtooth modulation, a copy happens only on the first trigger after software has refreshed a buffer. A pending flag tracks that refresh. In this mode the dead-time timer starts on any transfer trigger, including a software trigger write, as well as on one-shot falling edges. Sawtooth mode is meant for the simple counter mode, with the carrier timer reloading on its own underflow.

Top module: `pwm_xfer_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `xfer_pulse`, `dt_trig` and `shift_q` are all 0. The pending flag is clear.
- R2: The transfer trigger is `uflow | sw_trig_wr | (period_wr & period_trig_en)`. A period write with `period_trig_en` low causes neither a copy nor a sawtooth dead-time pulse.
- R3: With `saw_mode`=0, every transfer trigger copies the buffers into the shift register. `shift_q` takes the value {buffer1, buffer0}, with buffer0 in bits PAT_W-1:0. `xfer_pulse` is high in the cycle after the trigger.
- R4: With `saw_mode`=1, a trigger copies the buffers only when the pending flag is set. Otherwise `shift_q` holds its value and `xfer_pulse` stays 0.
- R5: Asserting bit k of `buf_wr` loads `buf_wdata` into buffer k and sets the pending flag. A copy clears the flag. A write in the same cycle as a copy leaves the flag set, and the copy takes the old buffer content.
- R6: With `saw_mode`=0, `dt_trig` is high in the cycle after any bit of `oneshot_fall` is high, and is 0 otherwise, whatever the transfer trigger does.
- R7: With `saw_mode`=1, `dt_trig` is high in the cycle after a transfer trigger or any one-shot falling edge.
- R8: Sources that coincide give a single one-cycle pulse. Each strobe returns to 0 in the cycle after its sources go quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| saw_mode | input | 1 | 0 = triangular, 1 = sawtooth modulation |
| period_trig_en | input | 1 | Enables a carrier-period write as a transfer source |
| uflow | input | 1 | Carrier-timer underflow strobe |
| sw_trig_wr | input | 1 | Software trigger write strobe |
| period_wr | input | 1 | Carrier-period register write strobe |
| buf_wr | input | NUM_BUF | Per-buffer write strobes |
| buf_wdata | input | PAT_W | Pattern data for buffer writes |
| oneshot_fall | input | NUM_PH | One-shot falling-edge strobes from the phase timers |
| xfer_pulse | output | 1 | Registered pulse, one cycle after a copy |
| dt_trig | output | 1 | Registered dead-time timer start pulse |
| shift_q | output | NUM_BUF*PAT_W | Loaded shift register value |

## Verification
Every result passes through exactly one register. A stimulus applied in cycle t therefore shows on `xfer_pulse`, `dt_trig` and `shift_q` just after the next rising edge. A buffer write only becomes visible on `shift_q` after a later trigger copies it. The bench drives inputs on the falling edge and compares all three outputs a short delay after the following rising edge. It compares them against a model that is advanced once per cycle from the same inputs. This keeps each check aligned with the single register stage.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic {MOD_TRI = 1'b0, MOD_SAW = 1'b1} mod_e;
endpackage

// File: rtl/xfer_src_merge.sv
module xfer_src_merge #(
  parameter int NUM_PH = 3
) (
  input  logic              uflow,
  input  logic              sw_trig_wr,
  input  logic              period_wr,
  input  logic              period_trig_en,
  input  logic [NUM_PH-1:0] oneshot_fall,
  output logic              trig,
  output logic              os_any
);
  // R2: period writes qualify only when enabled
  always_comb begin
    trig   = uflow | sw_trig_wr | (period_wr & period_trig_en);
    os_any = |oneshot_fall;
  end
endmodule

// File: rtl/xfer_pattern_buf.sv
module xfer_pattern_buf
  import xfer_pkg::*;
#(
  parameter int PAT_W   = 6,
  parameter int NUM_BUF = 2,
  localparam int SH_W   = PAT_W * NUM_BUF
) (
  input  logic               clk,
  input  logic               rst,
  input  mod_e               mode,
  input  logic               trig,
  input  logic [NUM_BUF-1:0] buf_wr,
  input  logic [PAT_W-1:0]   buf_wdata,
  output logic               copy_now,
  output logic [SH_W-1:0]    shift_q
);
  logic [SH_W-1:0] buf_flat;
  logic            pending;

  genvar g;
  generate
    for (g = 0; g < NUM_BUF; g++) begin : g_buf
      logic [PAT_W-1:0] slot;
      always_ff @(posedge clk) begin
        if (rst)            slot <= '0;
        else if (buf_wr[g]) slot <= buf_wdata;
      end
      assign buf_flat[g*PAT_W +: PAT_W] = slot;
    end
  endgenerate

  // R3 / R4: triangular copies always, sawtooth only when refreshed
  always_comb copy_now = trig & ((mode == MOD_TRI) | pending);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      shift_q <= '0;
    end else begin
      if (|buf_wr)       pending <= 1'b1;
      else if (copy_now) pending <= 1'b0;
      if (copy_now)      shift_q <= buf_flat;
    end
  end

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|buf_wr) |=> pending);
  // R4
  saw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MOD_SAW && !pending) |=> $stable(shift_q));
endmodule

// File: rtl/xfer_strobe_gen.sv
module xfer_strobe_gen
  import xfer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  mod_e mode,
  input  logic trig,
  input  logic os_any,
  input  logic copy_now,
  output logic xfer_pulse,
  output logic dt_trig
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_pulse <= 1'b0;
      dt_trig    <= 1'b0;
    end else begin
      xfer_pulse <= copy_now;
      dt_trig    <= os_any | ((mode == MOD_SAW) & trig);
    end
  end

  // R3
  tri_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MOD_TRI && trig) |=> xfer_pulse);
  // R6
  tri_dt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MOD_TRI && !os_any) |=> !dt_trig);
  // R7
  saw_dt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MOD_SAW && trig) |=> dt_trig);
  // R8
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig && !os_any) |=> (!xfer_pulse && !dt_trig));
endmodule

// File: rtl/pwm_xfer_ctrl.sv
module pwm_xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int PAT_W   = 6,
  parameter int NUM_BUF = 2,
  parameter int NUM_PH  = 3,
  localparam int SH_W   = PAT_W * NUM_BUF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               saw_mode,
  input  logic               period_trig_en,
  input  logic               uflow,
  input  logic               sw_trig_wr,
  input  logic               period_wr,
  input  logic [NUM_BUF-1:0] buf_wr,
  input  logic [PAT_W-1:0]   buf_wdata,
  input  logic [NUM_PH-1:0]  oneshot_fall,
  output logic               xfer_pulse,
  output logic               dt_trig,
  output logic [SH_W-1:0]    shift_q
);
  mod_e mode;
  logic trig, os_any, copy_now;

  assign mode = saw_mode ? MOD_SAW : MOD_TRI;

  xfer_src_merge #(.NUM_PH(NUM_PH)) u_merge (
    .uflow(uflow), .sw_trig_wr(sw_trig_wr), .period_wr(period_wr),
    .period_trig_en(period_trig_en), .oneshot_fall(oneshot_fall),
    .trig(trig), .os_any(os_any));

  xfer_pattern_buf #(.PAT_W(PAT_W), .NUM_BUF(NUM_BUF)) u_buf (
    .clk(clk), .rst(rst), .mode(mode), .trig(trig), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .copy_now(copy_now), .shift_q(shift_q));

  xfer_strobe_gen u_strb (
    .clk(clk), .rst(rst), .mode(mode), .trig(trig), .os_any(os_any),
    .copy_now(copy_now), .xfer_pulse(xfer_pulse), .dt_trig(dt_trig));

  // R2
  no_period_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (!uflow && !sw_trig_wr && !period_trig_en) |=> !xfer_pulse);
endmodule

// File: tb/pwm_xfer_ctrl_test.sv
module pwm_xfer_ctrl_test;
  localparam int PW = 6;
  logic clk = 1'b0, rst = 1'b1;
  logic saw = 0, en = 0, uf = 0, sw = 0, pw = 0;
  logic [1:0] bw = '0;
  logic [PW-1:0] wd = '0;
  logic [2:0] os = '0;
  logic xp, dt;
  logic [2*PW-1:0] sq;

  int n_run = 0, n_fail = 0;
  logic [PW-1:0] mb0 = '0, mb1 = '0;
  logic mpend = 0;
  logic [2*PW-1:0] mshift = '0;
  logic ex_x, ex_dt;

  always #10 clk = ~clk;

  pwm_xfer_ctrl uut (
    .clk(clk), .rst(rst), .saw_mode(saw), .period_trig_en(en), .uflow(uf),
    .sw_trig_wr(sw), .period_wr(pw), .buf_wr(bw), .buf_wdata(wd),
    .oneshot_fall(os), .xfer_pulse(xp), .dt_trig(dt), .shift_q(sq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_trig(logic u, logic s, logic p, logic e);
    return u | s | (p & e);
  endfunction

  task automatic step(input logic m, input logic e, input logic u, input logic s,
                      input logic p, input logic [1:0] w, input logic [PW-1:0] d,
                      input logic [2:0] o);
    logic t, cp;
    @(negedge clk);
    saw = m; en = e; uf = u; sw = s; pw = p; bw = w; wd = d; os = o;
    t  = f_trig(u, s, p, e);
    cp = t & (!m | mpend);
    ex_x  = cp;
    ex_dt = (|o) | (m & t);
    if (cp) mshift = {mb1, mb0};
    mpend = (|w) | (mpend & !cp);
    if (w[0]) mb0 = d;
    if (w[1]) mb1 = d;
    @(posedge clk); #2;
    chk(m ? "R4 xfer" : "R3 xfer", xp, ex_x);
    chk(m ? "R7 dt" : "R6 dt", dt, ex_dt);
    chk(m ? "R5 shift" : "R3 shift", sq, mshift);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 xfer", xp, 0); chk("R1 dt", dt, 0); chk("R1 shift", sq, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #2;
    chk("R1 post", {xp, dt, sq}, 0);
    // R2: disabled period write does nothing in either mode
    step(0, 0, 0, 0, 1, 2'b00, 0, 0);
    step(1, 0, 0, 0, 1, 2'b00, 0, 0);
    // R5: load buffers, then triangular copy R3
    step(0, 0, 0, 0, 0, 2'b01, 6'h15, 0);
    step(0, 0, 0, 0, 0, 2'b10, 6'h2a, 0);
    step(0, 1, 0, 0, 1, 2'b00, 0, 0);
    // R4: sawtooth with pending cleared -> no copy, R7 dt still fires
    step(1, 0, 1, 0, 0, 2'b00, 0, 0);
    step(1, 0, 0, 1, 0, 2'b00, 0, 0);
    // R5: write coincident with a copy keeps pending set
    step(1, 0, 0, 0, 0, 2'b01, 6'h07, 0);
    step(1, 0, 1, 0, 0, 2'b10, 6'h33, 0);
    step(1, 0, 1, 0, 0, 2'b00, 0, 0);
    step(1, 0, 1, 0, 0, 2'b00, 0, 0);
    // R6: one-shot edge in triangular mode, R8 merged sources
    step(0, 1, 1, 1, 1, 2'b00, 0, 3'b111);
    step(0, 0, 0, 0, 0, 2'b00, 0, 3'b000);
    step(0, 0, 0, 0, 0, 2'b00, 0, 3'b100);
    step(0, 0, 0, 0, 0, 2'b00, 0, 3'b000);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((i / 250) % 2 == 1, r[0], r[3:1] == 0, r[6:4] == 0, r[8:7] == 0,
           (r[11:9] == 0) ? r[13:12] : 2'b00, r[19:14],
           (r[22:20] == 0) ? r[25:23] : 3'b000);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule